// File: doc/BRIEF.md
# Interrupt Acceptance and Processor Status Word

This block keeps the processor status word of a small CPU core and decides, cycle by cycle, whether a pending maskable interrupt request or a software interrupt is taken. The word combines control fields (register-bank select, interrupt enable, stack-pointer select, a 3-bit processor priority level, a fixed-point radix-point bit and a 2-bit floating-point rounding mode) with result flags that the integer and floating-point units update through strobes.

A maskable request carries a 3-bit level. It is taken only while interrupts are enabled and its level is strictly above the current priority level. A software interrupt strobe is always taken. Taking any interrupt clears the enable flag. Hardware interrupts, and software interrupts with vector numbers below 128, also switch the core to the interrupt stack. The core reads the whole word, a one-cycle accept pulse, and two decoded indicators that select the stack pointer and the register bank. Vector fetch, state stacking and the arithmetic units are outside the block.

Word layout, with bit 0 as the least significant bit: bit 0 integer overflow, bit 1 FP underflow, bit 2 FP overflow, bit 3 radix point, bits 5:4 rounding mode, bit 6 reserved, bit 7 bank select, bit 8 interrupt enable, bit 9 stack select, bits 12:10 priority level, bits 15:13 unused.

Top module: `irq_status_unit`

## Requirements
- R1: A synchronous active-high reset clears the whole word to 0 and holds `accept` low. Interrupts are then disabled, the interrupt stack (stack select 0) is chosen, and bank 0 is active.
- R2: A maskable request is taken when `irq_req` is 1, enable bit 8 is 1 and `irq_lvl` is strictly greater than the priority level in bits 12:10. `accept` rises on the clock edge that samples the request.
- R3: A request whose level is equal to or below the priority level, or that arrives while bit 8 is 0, is not taken. A priority level of 7 blocks every maskable request.
- R4: Taking any interrupt, maskable or software, leaves enable bit 8 at 0 after the accepting edge.
- R5: Stack select bit 9 goes to 0 when a maskable request is taken and when a software interrupt with `swi_vec` below 128 is taken. A software interrupt with `swi_vec` of 128 or more leaves bit 9 unchanged. Software interrupts are taken whatever the enable flag and the priority level are.
- R6: `use_user_sp` equals stack select bit 9 (1 selects the user stack pointer, 0 the interrupt stack pointer). `bank_sel` equals bit 7.
- R7: On `fpu_upd`, bit 1 becomes `fpu_unf | fpu_subn` and bit 2 becomes `fpu_ovf | fpu_subn`. Without the strobe, both bits keep their values.
- R8: On `alu_upd`, bit 0 takes the value of `alu_ovf`. Without the strobe, bit 0 is held.
- R9: `wr_en` loads `wr_data` into the word. Reserved bit 6 and bits 15:13 always read 0.
- R10: In a cycle where a write coincides with an accept, the accept's clearing of bits 8 and 9 wins over the written values. Flag strobes in the same cycle as a write win over the written bits 0 to 2.
- R11: `accept` is high for exactly one cycle per accepted event. A maskable request held high produces a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Maskable interrupt request valid |
| irq_lvl | input | 3 | Level of the maskable request |
| swi_stb | input | 1 | Software interrupt strobe |
| swi_vec | input | VEC_W | Software interrupt vector number |
| wr_en | input | 1 | Write strobe for the whole word |
| wr_data | input | 16 | Value to write |
| alu_upd | input | 1 | Integer flag update strobe |
| alu_ovf | input | 1 | Integer overflow result |
| fpu_upd | input | 1 | Floating-point flag update strobe |
| fpu_unf | input | 1 | Floating-point underflow exception |
| fpu_ovf | input | 1 | Floating-point overflow exception |
| fpu_subn | input | 1 | Subnormal operand seen |
| psw_q | output | 16 | Current status word |
| accept | output | 1 | One-cycle pulse for a taken interrupt |
| use_user_sp | output | 1 | 1 selects the user stack pointer |
| bank_sel | output | 1 | Active register bank |

## Verification
Maskable requests are driven at levels below, equal to and above the priority level, and also with the enable flag cleared and with level 7. These cases separate the strict comparison from an inclusive one and show whether the enable gate is honoured. Software interrupts are issued with vectors on both sides of 128, with the stack-select bit set beforehand, so a wrong vector threshold appears as a stack-select difference. Writes that coincide with accepts and with flag strobes, followed by long random mixes of every input, expose any wrong ordering of the overlapping updates.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int PSW_W       = 16;
    localparam int LVL_W       = 3;
    localparam int RND_W       = 2;
    localparam int PAD_W       = PSW_W - 13;
    localparam int SWI_LOW_LIM = 128;
    localparam int SWI_LOW_W   = 7;

    // Status word, most significant field first.
    typedef struct packed {
        logic [PAD_W-1:0] pad;
        logic [LVL_W-1:0] lvl;
        logic             stk;
        logic             ien;
        logic             bank;
        logic             rsvd;
        logic [RND_W-1:0] rnd;
        logic             radix;
        logic             fof;
        logic             fuf;
        logic             ovf;
    } psw_t;

    typedef struct packed {
        logic hw_take;
        logic sw_take;
        logic clr_stk;
    } acc_t;

    typedef struct packed {
        logic upd;
        logic unf;
        logic ovf;
        logic subn;
    } fpu_evt_t;

    function automatic psw_t psw_clean(input psw_t w);
        psw_t r;
        r      = w;
        r.rsvd = 1'b0;
        r.pad  = '0;
        return r;
    endfunction

    function automatic psw_t apply_fpu(input psw_t w, input fpu_evt_t e);
        psw_t r;
        r = w;
        if (e.upd) begin
            r.fuf = e.unf | e.subn;
            r.fof = e.ovf | e.subn;
        end
        return r;
    endfunction

endpackage

// File: rtl/psw_accept_ctrl.sv
module psw_accept_ctrl
    import psw_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             ien,
    input  logic [LVL_W-1:0] cur_lvl,
    input  logic             irq_req,
    input  logic [LVL_W-1:0] irq_lvl,
    input  logic             swi_stb,
    input  logic [VEC_W-1:0] swi_vec,
    output acc_t             acc
);

    logic vec_low;

    generate
        if (VEC_W > SWI_LOW_W) begin : g_wide_vec
            assign vec_low = (swi_vec[VEC_W-1:SWI_LOW_W] == '0);
        end else begin : g_narrow_vec
            logic unused_vec;
            assign unused_vec = ^swi_vec;
            assign vec_low    = 1'b1;
        end
    endgenerate

    always_comb begin
        acc.hw_take = irq_req & ien & (irq_lvl > cur_lvl);
        acc.sw_take = swi_stb;
        acc.clr_stk = acc.hw_take | (swi_stb & vec_low);
    end

endmodule

// File: rtl/psw_next_calc.sv
module psw_next_calc
    import psw_pkg::*;
(
    input  psw_t             cur,
    input  logic             wr_en,
    input  logic [PSW_W-1:0] wr_data,
    input  logic             alu_upd,
    input  logic             alu_ovf,
    input  fpu_evt_t         fpu,
    input  acc_t             acc,
    output psw_t             nxt
);

    psw_t base;
    psw_t flagged;

    always_comb begin
        base = wr_en ? psw_t'(wr_data) : cur;
        base = psw_clean(base);

        flagged = base;
        if (alu_upd) begin
            flagged.ovf = alu_ovf;
        end
        flagged = apply_fpu(flagged, fpu);

        nxt = flagged;
        if (acc.hw_take | acc.sw_take) begin
            nxt.ien = 1'b0;
        end
        if (acc.clr_stk) begin
            nxt.stk = 1'b0;
        end
    end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import psw_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_req,
    input  logic [2:0]       irq_lvl,
    input  logic             swi_stb,
    input  logic [VEC_W-1:0] swi_vec,
    input  logic             wr_en,
    input  logic [15:0]      wr_data,
    input  logic             alu_upd,
    input  logic             alu_ovf,
    input  logic             fpu_upd,
    input  logic             fpu_unf,
    input  logic             fpu_ovf,
    input  logic             fpu_subn,
    output logic [15:0]      psw_q,
    output logic             accept,
    output logic             use_user_sp,
    output logic             bank_sel
);

    psw_t     psw_r;
    psw_t     psw_n;
    acc_t     acc;
    fpu_evt_t fpu_evt;
    logic     accept_r;

    assign fpu_evt = '{upd: fpu_upd, unf: fpu_unf, ovf: fpu_ovf, subn: fpu_subn};

    psw_accept_ctrl #(.VEC_W(VEC_W)) u_accept (
        .ien     (psw_r.ien),
        .cur_lvl (psw_r.lvl),
        .irq_req (irq_req),
        .irq_lvl (irq_lvl),
        .swi_stb (swi_stb),
        .swi_vec (swi_vec),
        .acc     (acc)
    );

    psw_next_calc u_next (
        .cur     (psw_r),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .alu_upd (alu_upd),
        .alu_ovf (alu_ovf),
        .fpu     (fpu_evt),
        .acc     (acc),
        .nxt     (psw_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            psw_r    <= '0;
            accept_r <= 1'b0;
        end else begin
            psw_r    <= psw_n;
            accept_r <= acc.hw_take | acc.sw_take;
        end
    end

    assign psw_q       = psw_r;
    assign accept      = accept_r;
    assign use_user_sp = psw_r.stk;
    assign bank_sel    = psw_r.bank;

endmodule

// File: rtl/irq_status_unit_sva.sv
module irq_status_unit_sva #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             irq_req,
    input logic [2:0]       irq_lvl,
    input logic             swi_stb,
    input logic [VEC_W-1:0] swi_vec,
    input logic             wr_en,
    input logic [15:0]      psw_q,
    input logic             accept
);

    logic hw_ok;
    assign hw_ok = irq_req && psw_q[8] && (irq_lvl > psw_q[12:10]);

    assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (rst)
        psw_q[6] == 1'b0 && psw_q[15:13] == 3'b000);

    assert_lvl7_block_R3: assert property (@(posedge clk) disable iff (rst)
        (irq_req && psw_q[12:10] == 3'd7 && !swi_stb) |=> !accept);

    assert_accept_clears_ien_R4: assert property (@(posedge clk) disable iff (rst)
        accept |-> !psw_q[8]);

    assert_hw_clears_stk_R5: assert property (@(posedge clk) disable iff (rst)
        hw_ok |=> (accept && !psw_q[9]));

    assert_hi_vec_keeps_stk_R5: assert property (@(posedge clk) disable iff (rst)
        (swi_stb && (32'(swi_vec) >= 32'd128) && !wr_en && !hw_ok)
        |=> (accept && psw_q[9] == $past(psw_q[9])));

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        (accept && !swi_stb) |=> !accept);

endmodule

bind irq_status_unit irq_status_unit_sva #(.VEC_W(VEC_W)) u_sva (
    .clk     (clk),
    .rst     (rst),
    .irq_req (irq_req),
    .irq_lvl (irq_lvl),
    .swi_stb (swi_stb),
    .swi_vec (swi_vec),
    .wr_en   (wr_en),
    .psw_q   (psw_q),
    .accept  (accept)
);

// File: tb/irq_status_unit_tb.sv
`timescale 1ns/1ps
module irq_status_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_req = 0, swi_stb = 0, wr_en = 0;
    logic [2:0]  irq_lvl = 0;
    logic [7:0]  swi_vec = 0;
    logic [15:0] wr_data = 0;
    logic        alu_upd = 0, alu_ovf = 0, fpu_upd = 0, fpu_unf = 0, fpu_ovf = 0, fpu_subn = 0;
    logic [15:0] psw_q;
    logic        accept, use_user_sp, bank_sel;

    int n_vec  = 0;
    int n_fail = 0;
    logic [15:0] m_word = 16'h0;
    logic        m_acc  = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_unit #(.VEC_W(8)) u_dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_lvl(irq_lvl),
        .swi_stb(swi_stb), .swi_vec(swi_vec), .wr_en(wr_en), .wr_data(wr_data),
        .alu_upd(alu_upd), .alu_ovf(alu_ovf), .fpu_upd(fpu_upd), .fpu_unf(fpu_unf),
        .fpu_ovf(fpu_ovf), .fpu_subn(fpu_subn), .psw_q(psw_q), .accept(accept),
        .use_user_sp(use_user_sp), .bank_sel(bank_sel)
    );

    task automatic check(input string tag);
        n_vec++;
        if (psw_q !== m_word) begin
            n_fail++;
            $display("FAIL %s word: actual %h expected %h", tag, psw_q, m_word);
        end
        if (accept !== m_acc) begin
            n_fail++;
            $display("FAIL %s accept: actual %b expected %b", tag, accept, m_acc);
        end
        if (use_user_sp !== m_word[9] || bank_sel !== m_word[7]) begin
            n_fail++;
            $display("FAIL R6 (%s) sp/bank: actual %b%b expected %b%b",
                     tag, use_user_sp, bank_sel, m_word[9], m_word[7]);
        end
    endtask

    // Check the state in force, then drive one cycle of stimulus and advance the model.
    task automatic step(input bit rq, input logic [2:0] lv, input bit sw, input logic [7:0] vec,
                        input bit we, input logic [15:0] wd, input bit au, input bit ao,
                        input bit fu, input bit fue, input bit foe, input bit fs,
                        input string tag);
        logic [15:0] n;
        bit hw;
        @(negedge clk);
        check(tag);
        irq_req = rq; irq_lvl = lv; swi_stb = sw; swi_vec = vec;
        wr_en = we; wr_data = wd; alu_upd = au; alu_ovf = ao;
        fpu_upd = fu; fpu_unf = fue; fpu_ovf = foe; fpu_subn = fs;
        n = we ? (wd & 16'h1FBF) : m_word;
        if (au) n[0] = ao;
        if (fu) begin
            n[1] = fue | fs;
            n[2] = foe | fs;
        end
        hw = rq && m_word[8] && (lv > m_word[12:10]);
        if (hw || sw) n[8] = 1'b0;
        if (hw || (sw && vec < 8'd128)) n[9] = 1'b0;
        m_acc  = hw || sw;
        m_word = n;
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic wr(input logic [15:0] d, input string tag);
        step(0, 0, 0, 0, 1, d, 0, 0, 0, 0, 0, 0, tag);
    endtask

    function automatic logic [15:0] mk(input bit ien, input bit stk, input bit bank, input logic [2:0] lvl);
        return {3'b000, lvl, stk, ien, bank, 7'h00};
    endfunction

    initial begin : watchdog
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle("R1");

        // Load enable, level 3, stack and bank set; attempt reserved bit and pad.
        wr(mk(1, 1, 1, 3) | 16'hE040 | 16'h003F, "R9");
        idle("R6");
        step(1, 3'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
        step(1, 3'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
        step(1, 3'd4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 3'd4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
        idle("R4");
        idle("R5");

        // Level 7 blocks everything.
        wr(mk(1, 1, 0, 7), "R3");
        step(1, 3'd7, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
        idle("R3");

        // Software interrupts on both sides of 128, with enable cleared.
        wr(mk(0, 1, 1, 5), "R5");
        step(0, 0, 1, 8'd200, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
        idle("R5");
        step(0, 0, 1, 8'd128, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
        step(0, 0, 1, 8'd127, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
        idle("R5");

        // Write coinciding with accept and with flag strobes.
        wr(mk(1, 0, 0, 0), "R10");
        step(1, 3'd1, 0, 0, 1, mk(1, 1, 1, 2), 0, 0, 0, 0, 0, 0, "R10");
        idle("R10");
        step(0, 0, 0, 0, 1, 16'h0007, 1, 0, 1, 0, 1, 0, "R10");
        idle("R10");

        // Flag units.
        step(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, "R8");
        idle("R7");

        // Random mix.
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 2) == 0, 3'($urandom), ($urandom % 8) == 0, 8'($urandom),
                 ($urandom % 6) == 0, 16'($urandom), ($urandom % 3) == 0, 1'($urandom),
                 ($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
                 ($urandom % 5) == 0, "R2");
        end
        idle("R11");
        @(negedge clk);
        check("R11");

        // Reset mid-run clears everything.
        wr(mk(1, 1, 1, 6) | 16'h0007, "R9");
        @(negedge clk);
        check("R9");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_word = 16'h0;
        m_acc  = 1'b0;
        check("R1");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule